// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Block Detection

This block turns a serial RX line into characters. It uses a baud tick that runs at sixteen times the bit rate, and it takes a set of format inputs that the matching transmitter also uses: seven or eight data bits, optional even or odd parity, one or two stop bits, and LSB-first or MSB-first order. Each finished character goes into a holding register and is offered on a valid/acknowledge handshake. The held character comes with parity, framing and overrun flags, and with an address tag.

For multi-drop links, an idle-line mode splits the traffic into blocks. After a character, the receiver counts mark bit-times on the line. When enough of them have passed, it raises an idle flag and stops counting until the next start edge arrives. It tags the first character that follows as an address. Reading that address character clears the idle flag. A software reset input clears every flag and the holding register, and the receiver ignores the line for as long as that input is high.

Top module: `uart_idle_rx`

## Requirements
- R1: After `rst_n` is released, and in every cycle after a cycle with `soft_rst` high, `rx_valid`, `parity_err`, `frame_err`, `overrun_err`, `idle_detected` and `rx_is_addr` are 0.
- R2: A character of start (0), data, optional parity and stop bit(s) sets `rx_valid` with its data on `rx_data` by the end of its stop bit. A cycle with `rx_ack` high while `rx_valid` is high clears `rx_valid` and all error flags.
- R3: With `fmt_eight`=0 only seven data bits are received, and `rx_data[7]` reads 0.
- R4: With `fmt_msb_first`=1 the first data bit received lands in the highest data bit in use. With `fmt_msb_first`=0 it lands in bit 0.
- R5: With `fmt_par_en`=1 a parity bit follows the data. The expected value makes the count of ones over data plus parity even (`fmt_par_odd`=0) or odd (`fmt_par_odd`=1). A mismatch sets `parity_err` for that character.
- R6: A 0 sampled in the first stop bit sets `frame_err` for that character.
- R7: With `fmt_two_stop`=1 the second stop bit is consumed but not checked: a 0 there leaves `frame_err` at 0.
- R8: A character that completes while the previous one is still unacknowledged replaces `rx_data` and sets `overrun_err`.
- R9: A start is accepted only on a falling edge that still reads low 8 ticks later. A low pulse shorter than that produces no character.
- R10: With `idle_mode_en`=1, `idle_detected` rises once the line has stayed high for 10 bit-times plus the second half of the stop bit. It stays 0 after only 8 such bit-times.
- R11: In idle-line mode the first character whose start follows an idle detection has `rx_is_addr`=1. Later characters have `rx_is_addr`=0.
- R12: Acknowledging a character with `rx_is_addr`=1 clears `idle_detected`.
- R13: With `idle_mode_en`=0, `idle_detected` and `rx_is_addr` stay 0 however long the line is idle.
- R14: While `soft_rst` is high a full character on the line produces no `rx_valid`. Normal reception resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset: clears flags and holds the receiver off the line |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| fmt_eight | input | 1 | 1: eight data bits, 0: seven |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even |
| fmt_two_stop | input | 1 | Two stop bits |
| fmt_msb_first | input | 1 | Data bits arrive MSB first |
| idle_mode_en | input | 1 | Enable idle-line block detection |
| rx_valid | output | 1 | Held character available |
| rx_data | output | 8 | Held character data |
| rx_is_addr | output | 1 | Held character is the first after an idle period |
| rx_ack | input | 1 | Consume the held character |
| parity_err | output | 1 | Parity mismatch on held character |
| frame_err | output | 1 | First stop bit read 0 on held character |
| overrun_err | output | 1 | Held character overwrote an unread one |
| idle_detected | output | 1 | Idle line seen since the last address character was read |

## Verification
The hardest behaviour to reach is the idle threshold. It is counted from the middle of the last stop bit and is measured in ticks, not in clocks, so a gap of eight bit-times must leave the flag low and a gap of twelve must raise it. The bench drives the line at exact tick boundaries and holds it high for those two measured gaps after a character. It does this only after the address character has been read, which clears the earlier idle flag. The address tag also needs a character that starts after an idle period, followed by a second character sent after a one-bit gap, so that the tag is seen to drop after the first character.

// File: rtl/uart_idle_rx_pkg.sv
package uart_idle_rx_pkg;

  typedef enum logic [2:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       addr;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_inputs.sv
module uart_rx_inputs (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic rst_n_s,
  output logic rx_s
);

  logic [1:0] rst_pipe_q;
  logic [1:0] rx_pipe_q;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  // line synchronizer, resets to mark
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_pipe_q <= 2'b11;
    else        rx_pipe_q <= {rx_pipe_q[0], rx_line};
  end

  assign rst_n_s = rst_pipe_q[1];
  assign rx_s    = rx_pipe_q[1];

endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_idle_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     tick,
  input  logic     rx_s,
  input  logic     fmt_eight,
  input  logic     fmt_par_en,
  input  logic     fmt_par_odd,
  input  logic     fmt_two_stop,
  input  logic     fmt_msb_first,
  input  logic     idle_tag_i,
  output logic     hunting_o,
  output logic     start_ok_o,
  output logic     done_o,
  output rx_char_t char_o
);

  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  rx_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [DW-1:0]   data_q, data_d;
  logic            acc_q, acc_d;
  logic            perr_q, perr_d;
  logic            ferr_q, ferr_d;
  logic            addr_q, addr_d;
  logic            last_q, last_d;
  logic [IW-1:0]   nbits_m1;
  logic [IW-1:0]   bit_pos;
  logic            mid;
  logic            ferr_now;

  assign nbits_m1 = fmt_eight ? IW'(DW - 1) : IW'(DW - 2);
  assign bit_pos  = fmt_msb_first ? (nbits_m1 - idx_q) : idx_q;
  assign mid      = tick && (cnt_q == CW'(OSR - 1));

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    data_d     = data_q;
    acc_d      = acc_q;
    perr_d     = perr_q;
    ferr_d     = ferr_q;
    addr_d     = addr_q;
    last_d     = tick ? rx_s : last_q;
    start_ok_o = 1'b0;
    done_o     = 1'b0;
    ferr_now   = ferr_q;

    if (soft_rst) begin
      state_d = RX_HUNT;
      cnt_d   = '0;
      last_d  = 1'b0;
    end else begin
      if (tick && state_q != RX_HUNT && state_q != RX_START)
        cnt_d = mid ? '0 : cnt_q + CW'(1);
      case (state_q)
        RX_HUNT: begin
          cnt_d = '0;
          if (tick && !rx_s && last_q) state_d = RX_START;
        end
        RX_START: begin
          if (tick) begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_d = '0;
              if (!rx_s) begin
                state_d    = RX_DATA;
                idx_d      = '0;
                data_d     = '0;
                acc_d      = 1'b0;
                perr_d     = 1'b0;
                ferr_d     = 1'b0;
                addr_d     = idle_tag_i;
                start_ok_o = 1'b1;
              end else begin
                state_d = RX_HUNT;
              end
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        RX_DATA: begin
          if (mid) begin
            data_d[bit_pos] = rx_s;
            acc_d           = acc_q ^ rx_s;
            if (idx_q == nbits_m1) state_d = fmt_par_en ? RX_PAR : RX_STOP1;
            else                   idx_d   = idx_q + IW'(1);
          end
        end
        RX_PAR: begin
          if (mid) begin
            perr_d  = rx_s ^ acc_q ^ fmt_par_odd;
            state_d = RX_STOP1;
          end
        end
        RX_STOP1: begin
          if (mid) begin
            ferr_d   = !rx_s;
            ferr_now = !rx_s;
            if (fmt_two_stop) begin
              state_d = RX_STOP2;
            end else begin
              state_d = RX_HUNT;
              done_o  = 1'b1;
            end
          end
        end
        RX_STOP2: begin
          if (mid) begin
            state_d = RX_HUNT;
            done_o  = 1'b1;
          end
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      addr_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      addr_q  <= addr_d;
      last_q  <= last_d;
    end
  end

  assign hunting_o   = (state_q == RX_HUNT);
  assign char_o.data = 8'(data_q);
  assign char_o.perr = perr_q;
  assign char_o.ferr = ferr_now;
  assign char_o.addr = addr_q;

  // R14
  srst_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> hunting_o);

  // R9
  start_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_o |-> (state_q == RX_START) && $past(!hunting_o));

endmodule

// File: rtl/uart_rx_idle_det.sv
module uart_rx_idle_det #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tick,
  input  logic rx_s,
  input  logic enable,
  input  logic hunting,
  input  logic start_ok,
  output logic idle_tag_o,
  output logic idle_pulse_o
);

  localparam int LIMIT = IDLE_BITS * OSR + OSR / 2;
  localparam int W     = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         seen_q, seen_d;

  always_comb begin
    cnt_d        = cnt_q;
    seen_d       = seen_q;
    idle_pulse_o = 1'b0;
    if (soft_rst || !enable) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (start_ok) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (!hunting) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!rx_s) begin
        cnt_d = '0;
      end else if (cnt_q < W'(LIMIT)) begin
        cnt_d = cnt_q + W'(1);
        if (cnt_q == W'(LIMIT - 1)) begin
          idle_pulse_o = 1'b1;
          seen_d       = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign idle_tag_o = seen_q;

  // R10
  idle_from_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_tag_o) |-> $past(hunting) && $past(rx_s));

  // R13
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !idle_tag_o);

endmodule

// File: rtl/uart_rx_holdreg.sv
module uart_rx_holdreg
  import uart_idle_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       done_i,
  input  rx_char_t   char_i,
  input  logic       idle_pulse_i,
  input  logic       rx_ack,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_is_addr,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err,
  output logic       idle_detected
);

  logic       valid_q, valid_d;
  logic [7:0] data_q, data_d;
  logic       addr_q, addr_d;
  logic       perr_q, perr_d;
  logic       ferr_q, ferr_d;
  logic       ovr_q, ovr_d;
  logic       idle_q, idle_d;
  logic       pop;

  assign pop = rx_ack && valid_q;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    addr_d  = addr_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;
    idle_d  = idle_q;
    if (soft_rst) begin
      valid_d = 1'b0;
      data_d  = '0;
      addr_d  = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
      ovr_d   = 1'b0;
      idle_d  = 1'b0;
    end else begin
      if (pop) begin
        valid_d = 1'b0;
        perr_d  = 1'b0;
        ferr_d  = 1'b0;
        ovr_d   = 1'b0;
        addr_d  = 1'b0;
        if (addr_q) idle_d = 1'b0;
      end
      if (done_i) begin
        valid_d = 1'b1;
        data_d  = char_i.data;
        addr_d  = char_i.addr;
        perr_d  = char_i.perr;
        ferr_d  = char_i.ferr;
        if (valid_q && !pop) ovr_d = 1'b1;
      end
      if (idle_pulse_i) idle_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      addr_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      addr_q  <= addr_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
      idle_q  <= idle_d;
    end
  end

  assign rx_valid      = valid_q;
  assign rx_data       = data_q;
  assign rx_is_addr    = addr_q;
  assign parity_err    = perr_q;
  assign frame_err     = ferr_q;
  assign overrun_err   = ovr_q;
  assign idle_detected = idle_q;

  // R1
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !rx_valid && !parity_err && !frame_err && !overrun_err && !idle_detected);

  // R8
  ovr_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(rx_valid) && $past(!rx_ack));

  // R2
  ack_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && rx_valid && !done_i) |=> !rx_valid);

  // R12
  addr_read_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && rx_valid && rx_is_addr && !idle_pulse_i && !soft_rst) |=> !idle_detected);

endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
  import uart_idle_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       baud_tick,
  input  logic       rx_line,
  input  logic       fmt_eight,
  input  logic       fmt_par_en,
  input  logic       fmt_par_odd,
  input  logic       fmt_two_stop,
  input  logic       fmt_msb_first,
  input  logic       idle_mode_en,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_is_addr,
  input  logic       rx_ack,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err,
  output logic       idle_detected
);

  logic     rst_n_s;
  logic     rx_s;
  logic     hunting;
  logic     start_ok;
  logic     done;
  logic     idle_tag;
  logic     idle_pulse;
  rx_char_t char_w;

  uart_rx_inputs u_inputs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_line (rx_line),
    .rst_n_s (rst_n_s),
    .rx_s    (rx_s)
  );

  uart_rx_deframer #(.OSR(OSR), .DW(8)) u_deframer (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .soft_rst      (soft_rst),
    .tick          (baud_tick),
    .rx_s          (rx_s),
    .fmt_eight     (fmt_eight),
    .fmt_par_en    (fmt_par_en),
    .fmt_par_odd   (fmt_par_odd),
    .fmt_two_stop  (fmt_two_stop),
    .fmt_msb_first (fmt_msb_first),
    .idle_tag_i    (idle_tag),
    .hunting_o     (hunting),
    .start_ok_o    (start_ok),
    .done_o        (done),
    .char_o        (char_w)
  );

  uart_rx_idle_det #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .soft_rst     (soft_rst),
    .tick         (baud_tick),
    .rx_s         (rx_s),
    .enable       (idle_mode_en),
    .hunting      (hunting),
    .start_ok     (start_ok),
    .idle_tag_o   (idle_tag),
    .idle_pulse_o (idle_pulse)
  );

  uart_rx_holdreg u_hold (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .soft_rst      (soft_rst),
    .done_i        (done),
    .char_i        (char_w),
    .idle_pulse_i  (idle_pulse),
    .rx_ack        (rx_ack),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_is_addr    (rx_is_addr),
    .parity_err    (parity_err),
    .frame_err     (frame_err),
    .overrun_err   (overrun_err),
    .idle_detected (idle_detected)
  );

endmodule

// File: tb/uart_idle_rx_tb.sv
module uart_idle_rx_tb_top;

  logic clk = 1'b0;
  logic rst_n, soft_rst, baud_tick, rx_line;
  logic fmt_eight, fmt_par_en, fmt_par_odd, fmt_two_stop, fmt_msb_first, idle_mode_en;
  logic rx_valid, rx_is_addr, rx_ack, parity_err, frame_err, overrun_err, idle_detected;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  uart_idle_rx dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_tick(baud_tick),
    .rx_line(rx_line), .fmt_eight(fmt_eight), .fmt_par_en(fmt_par_en),
    .fmt_par_odd(fmt_par_odd), .fmt_two_stop(fmt_two_stop),
    .fmt_msb_first(fmt_msb_first), .idle_mode_en(idle_mode_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
    .rx_ack(rx_ack), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_err(overrun_err), .idle_detected(idle_detected)
  );

  // tick: one cycle in four
  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (baud_tick !== 1'b1) @(posedge clk);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_line = b;
    tick_wait(16);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic s1, input logic s2);
    int nb;
    logic p;
    nb = fmt_eight ? 8 : 7;
    p = fmt_par_odd ^ bad_par;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = fmt_msb_first ? d[nb-1-i] : d[i];
      p = p ^ b;
      send_bit(b);
    end
    if (fmt_par_en) send_bit(p);
    send_bit(s1);
    if (fmt_two_stop) send_bit(s2);
    @(negedge clk);
    rx_line = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_srst();
    @(negedge clk);
    soft_rst = 1'b1;
    repeat (2) @(negedge clk);
    soft_rst = 1'b0;
    idle_bits(2);
  endtask

  task automatic set_fmt(input logic e8, input logic pe, input logic po, input logic s2, input logic msb);
    fmt_eight = e8; fmt_par_en = pe; fmt_par_odd = po; fmt_two_stop = s2; fmt_msb_first = msb;
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", rx_valid, 0);
    chk("R1", "flags after reset", {parity_err, frame_err, overrun_err, idle_detected, rx_is_addr}, 0);
  endtask

  task automatic t_basic();
    set_fmt(1, 0, 0, 0, 0);
    send_frame(8'hA5, 0, 1, 1);
    chk("R2", "valid 8N1", rx_valid, 1);
    chk("R2", "data 8N1", rx_data, 8'hA5);
    chk("R2", "no errors 8N1", {parity_err, frame_err, overrun_err}, 0);
    do_ack();
    chk("R2", "valid after ack", rx_valid, 0);
    send_frame(8'h3C, 0, 1, 1);
    chk("R2", "second data", rx_data, 8'h3C);
    do_ack();
  endtask

  task automatic t_seven();
    set_fmt(0, 0, 0, 0, 0);
    send_frame(8'hD3, 0, 1, 1);
    chk("R3", "seven-bit data", rx_data, 8'h53);
    do_ack();
  endtask

  task automatic t_msb();
    set_fmt(1, 0, 0, 0, 1);
    send_frame(8'h1E, 0, 1, 1);
    chk("R4", "msb-first 8 bit", rx_data, 8'h1E);
    do_ack();
    set_fmt(0, 0, 0, 0, 1);
    send_frame(8'h41, 0, 1, 1);
    chk("R4", "msb-first 7 bit", rx_data, 8'h41);
    do_ack();
  endtask

  task automatic t_parity();
    set_fmt(1, 1, 0, 0, 0);
    send_frame(8'h37, 0, 1, 1);
    chk("R5", "even good", {rx_data, parity_err}, {8'h37, 1'b0});
    do_ack();
    send_frame(8'h37, 1, 1, 1);
    chk("R5", "even bad", parity_err, 1);
    do_ack();
    chk("R2", "parity flag cleared on ack", parity_err, 0);
    set_fmt(1, 1, 1, 0, 0);
    send_frame(8'h80, 0, 1, 1);
    chk("R5", "odd good", {rx_data, parity_err}, {8'h80, 1'b0});
    do_ack();
    send_frame(8'h80, 1, 1, 1);
    chk("R5", "odd bad", parity_err, 1);
    do_ack();
  endtask

  task automatic t_frame();
    set_fmt(1, 0, 0, 0, 0);
    send_frame(8'h5A, 0, 0, 1);
    chk("R6", "bad stop flag", frame_err, 1);
    chk("R6", "bad stop data", rx_data, 8'h5A);
    do_ack();
    idle_bits(1);
    chk("R6", "no false char after bad stop", rx_valid, 0);
  endtask

  task automatic t_two_stop();
    set_fmt(1, 0, 0, 1, 0);
    send_frame(8'hC3, 0, 1, 0);
    chk("R7", "second stop unchecked", {rx_valid, frame_err, rx_data}, {1'b1, 1'b0, 8'hC3});
    do_ack();
    idle_bits(1);
    send_frame(8'h11, 0, 0, 1);
    chk("R7", "first stop checked in two-stop", frame_err, 1);
    do_ack();
  endtask

  task automatic t_overrun();
    set_fmt(1, 0, 0, 0, 0);
    send_frame(8'h01, 0, 1, 1);
    chk("R8", "no overrun on first", overrun_err, 0);
    send_frame(8'h02, 0, 1, 1);
    chk("R8", "overrun set", overrun_err, 1);
    chk("R8", "data replaced", rx_data, 8'h02);
    do_ack();
    chk("R8", "overrun cleared by ack", {rx_valid, overrun_err}, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rx_line = 1'b0;
    tick_wait(4);
    @(negedge clk);
    rx_line = 1'b1;
    tick_wait(40);
    chk("R9", "short low rejected", rx_valid, 0);
  endtask

  task automatic t_idle();
    set_fmt(1, 0, 0, 0, 0);
    idle_mode_en = 1'b1;
    idle_bits(12);
    chk("R10", "idle after long mark", idle_detected, 1);
    send_frame(8'h41, 0, 1, 1);
    chk("R11", "first after idle tagged", {rx_valid, rx_is_addr, rx_data}, {1'b1, 1'b1, 8'h41});
    do_ack();
    chk("R12", "idle cleared by addr read", idle_detected, 0);
    idle_bits(1);
    send_frame(8'h42, 0, 1, 1);
    chk("R11", "next char not tagged", {rx_is_addr, rx_data}, {1'b0, 8'h42});
    do_ack();
    idle_bits(8);
    chk("R10", "no idle after 8 marks", idle_detected, 0);
    idle_bits(4);
    chk("R10", "idle after 12 marks", idle_detected, 1);
    send_frame(8'h43, 0, 1, 1);
    chk("R11", "tag after second idle", rx_is_addr, 1);
    do_ack();
  endtask

  task automatic t_mode_off();
    idle_mode_en = 1'b0;
    do_srst();
    idle_bits(14);
    chk("R13", "no idle with mode off", idle_detected, 0);
    send_frame(8'h44, 0, 1, 1);
    chk("R13", "no tag with mode off", {rx_is_addr, rx_data}, {1'b0, 8'h44});
    do_ack();
  endtask

  task automatic t_srst();
    set_fmt(1, 1, 0, 0, 0);
    send_frame(8'h01, 1, 0, 1);
    send_frame(8'h02, 1, 0, 1);
    chk("R1", "flags set before soft reset", {rx_valid, parity_err, frame_err, overrun_err}, 4'hF);
    @(negedge clk);
    soft_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "soft reset clears", {rx_valid, parity_err, frame_err, overrun_err, idle_detected}, 0);
    send_frame(8'h77, 0, 1, 1);
    chk("R14", "line ignored in soft reset", rx_valid, 0);
    soft_rst = 1'b0;
    idle_bits(3);
    chk("R14", "nothing after release", rx_valid, 0);
    send_frame(8'h66, 0, 1, 1);
    chk("R14", "resumes after release", {rx_valid, rx_data}, {1'b1, 8'h66});
    do_ack();
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; rx_line = 1'b1; rx_ack = 1'b0;
    idle_mode_en = 1'b0;
    set_fmt(1, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    idle_bits(1);
    t_basic();
    t_seven();
    t_msb();
    t_parity();
    t_frame();
    t_two_stop();
    t_overrun();
    t_glitch();
    t_idle();
    t_mode_off();
    t_srst();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule